// File: doc/BRIEF.md
# Serial Register Port with Write Lock

This block is a four-wire serial slave that fronts a 128-byte register space for surrounding control logic. The bus runs in mode 0 (clock idles low). Every transfer opens with a command byte: its top bit chooses write (1) or read (0) and its low seven bits give a start address. Each further byte moves to the next address, with the address rolling over from 0x7F back to 0x00, so one transfer can cover a run of registers.

The block keeps a read-only identity byte, a two-bit enable register, a six-bit limit configuration, three ten-bit current codes (each split across a pair of byte registers), a system byte at 0x11 and eight general bytes at 0x20 to 0x27. The window 0x11 to 0x27 is always readable, but writes to it land only while a lock, kept at address 0x10, is open. The lock opens when two key bytes are written to 0x10 back to back. All register values are driven out as ports for neighbouring logic. The bus pins are brought into the system clock domain through synchronizers, and the system clock must run at least four times faster than the serial clock.

Top module: `spi_regbank`

## Requirements
- R1: Serial input is taken on the rising serial clock edge and output changes after the falling edge; while chip select is high, input toggles change nothing and `miso_oe_o` is 0 (it is 1 while chip select is low).
- R2: The first byte of a transfer is a command: bit 7 = 1 means write, 0 means read; bits 6:0 are the start address.
- R3: Each data byte after the command goes to the next address, and address 0x7F is followed by 0x00.
- R4: After reset, 0x00 reads 0xA6, 0x01 reads 0x03, 0x02 reads 0x28, and every other address reads 0x00.
- R5: Read-only bits ignore writes: all of 0x00, bits 7:2 of 0x01, bits 7:6 of 0x02, and bits 7:2 of 0x03, 0x05 and 0x07 always read 0 (0x00 always reads 0xA6).
- R6: Current code n (n = 0..2) takes bits 9:8 from bits 1:0 of address 0x03+2n and bits 7:0 from address 0x04+2n, and is driven on `code_o[10n+9:10n]`.
- R7: While locked, writes to 0x11 through 0x27 have no effect; those addresses stay readable.
- R8: Writing 0xBA and then 0xBE to 0x10, with no other data byte access between them, unlocks; any other access between the two bytes breaks the sequence.
- R9: Writing to 0x10 any byte other than 0xBA (and other than a 0xBE that completes R8) locks again; a read of 0x10 returns 0x01 when unlocked and 0x00 when locked.
- R10: Bytes under a read command, and a final byte cut short by chip select rising, commit nothing.
- R11: Reads of unmapped addresses return 0x00 and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles low |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data into the block |
| miso_o | output | 1 | Serial data out of the block |
| miso_oe_o | output | 1 | Output enable for `miso_o` (1 = drive) |
| en_o | output | 2 | Enable register value (address 0x01) |
| lim_o | output | 6 | Limit configuration (address 0x02 bits 5:0) |
| code_o | output | 30 | Three 10-bit current codes, code n in bits 10n+9:10n |
| sys_o | output | 8 | Protected system byte (address 0x11) |
| user_o | output | 64 | Protected general bytes, byte k (address 0x20+k) in bits 8k+7:8k |

## Verification
The assertions assume the serial clock idles low in mode 0, each half period of it spans several system clocks, and chip select changes only while the serial clock is low, so synchronized edges arrive one at a time and in order. The bench drives every pin on the falling system clock edge with six system clocks per serial half period, raises chip select only with the serial clock low, and reads returned bits just before each rising serial edge. Stray serial clock activity is generated only with chip select high, where the block must ignore it.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int CODE_W = 10;

  localparam logic [ADDR_W-1:0] A_ID    = 7'h00;
  localparam logic [ADDR_W-1:0] A_EN    = 7'h01;
  localparam logic [ADDR_W-1:0] A_LIM   = 7'h02;
  localparam logic [ADDR_W-1:0] A_CODE0 = 7'h03;
  localparam logic [ADDR_W-1:0] A_KEY   = 7'h10;
  localparam logic [ADDR_W-1:0] A_SYS   = 7'h11;
  localparam logic [ADDR_W-1:0] A_USER0 = 7'h20;
  localparam logic [ADDR_W-1:0] PROT_LO = 7'h11;
  localparam logic [ADDR_W-1:0] PROT_HI = 7'h27;

  localparam logic [DATA_W-1:0] ID_VAL  = 8'hA6;
  localparam logic [1:0]        EN_RST  = 2'b11;
  localparam logic [5:0]        LIM_RST = 6'h28;
  localparam logic [DATA_W-1:0] KEY_A   = 8'hBA;
  localparam logic [DATA_W-1:0] KEY_B   = 8'hBE;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st_q[s] <= RST_VAL;
      else if (s == 0) st_q[s] <= d_i;
      else            st_q[s] <= st_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              sclk_s_i,
  input  logic              mosi_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              acc_stb_o,
  output logic              acc_wr_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [DATA_W-1:0] acc_data_o,
  output logic              miso_o
);
  localparam int BC_W = $clog2(DATA_W);

  logic              sclk_q;
  logic [BC_W-1:0]   bit_q;
  logic              first_q, is_wr_q;
  logic [DATA_W-1:0] sh_q, tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              stb_q, wr_q;
  logic [ADDR_W-1:0] aaddr_q;
  logic [DATA_W-1:0] adata_q;

  wire              rise     = sclk_s_i & ~sclk_q;
  wire              fall     = ~sclk_s_i & sclk_q;
  wire [DATA_W-1:0] byte_in  = {sh_q[DATA_W-2:0], mosi_s_i};
  wire              byte_end = rise && (bit_q == BC_W'(DATA_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      bit_q   <= '0;
      first_q <= 1'b1;
      is_wr_q <= 1'b0;
      sh_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      stb_q   <= 1'b0;
      wr_q    <= 1'b0;
      aaddr_q <= '0;
      adata_q <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      stb_q  <= 1'b0;
      wr_q   <= 1'b0;
      if (cs_s_i) begin
        bit_q   <= '0;
        first_q <= 1'b1;
        is_wr_q <= 1'b0;
        tx_q    <= '0;
      end else if (rise) begin
        sh_q  <= byte_in;
        bit_q <= bit_q + 1'b1;
        if (byte_end) begin
          if (first_q) begin
            first_q <= 1'b0;
            is_wr_q <= byte_in[DATA_W-1];
            addr_q  <= byte_in[ADDR_W-1:0];
          end else begin
            stb_q   <= 1'b1;
            wr_q    <= is_wr_q;
            aaddr_q <= addr_q;
            adata_q <= byte_in;
            addr_q  <= addr_q + 1'b1;
          end
        end
      end else if (fall) begin
        // byte boundary: fetch next read byte, otherwise shift out
        if (bit_q == '0) tx_q <= is_wr_q ? '0 : rd_data_i;
        else             tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign rd_addr_o  = addr_q;
  assign acc_stb_o  = stb_q;
  assign acc_wr_o   = wr_q;
  assign acc_addr_o = aaddr_q;
  assign acc_data_o = adata_q;
  assign miso_o     = tx_q[DATA_W-1];

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> !stb_q);
  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> addr_q == aaddr_q + 1'b1);
  assert_read_no_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_end && !first_q && !is_wr_q && !cs_s_i) |=> (stb_q && !wr_q));
endmodule

// File: rtl/spi_rb_regs.sv
module spi_rb_regs
  import spi_rb_pkg::*;
#(
  parameter int NUM_CODES = 3,
  parameter int USER_N    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        acc_stb_i,
  input  logic                        acc_wr_i,
  input  logic [ADDR_W-1:0]           acc_addr_i,
  input  logic [DATA_W-1:0]           acc_data_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic [1:0]                  en_o,
  output logic [5:0]                  lim_o,
  output logic [NUM_CODES*CODE_W-1:0] code_o,
  output logic [DATA_W-1:0]           sys_o,
  output logic [USER_N*DATA_W-1:0]    user_o
);
  localparam int HI_W = CODE_W - DATA_W;

  logic [1:0]        en_q;
  logic [5:0]        lim_q;
  logic [HI_W-1:0]   code_hi_q [NUM_CODES];
  logic [DATA_W-1:0] code_lo_q [NUM_CODES];
  logic [DATA_W-1:0] sys_q;
  logic [DATA_W-1:0] user_q [USER_N];
  logic              unlock_q, armed_q;

  wire wr_any = acc_stb_i && acc_wr_i;
  wire in_win = (acc_addr_i >= PROT_LO) && (acc_addr_i <= PROT_HI);
  wire wr_ok  = wr_any && (!in_win || unlock_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= EN_RST;
      lim_q    <= LIM_RST;
      sys_q    <= '0;
      unlock_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      if (wr_ok && acc_addr_i == A_EN)  en_q  <= acc_data_i[1:0];
      if (wr_ok && acc_addr_i == A_LIM) lim_q <= acc_data_i[5:0];
      if (wr_ok && acc_addr_i == A_SYS) sys_q <= acc_data_i;
      if (acc_stb_i) begin
        armed_q <= wr_any && acc_addr_i == A_KEY && acc_data_i == KEY_A;
        if (wr_any && acc_addr_i == A_KEY && acc_data_i != KEY_A)
          unlock_q <= (acc_data_i == KEY_B) && armed_q;
      end
    end
  end

  for (genvar n = 0; n < NUM_CODES; n++) begin : g_code
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(A_CODE0 + 2*n);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(A_CODE0 + 2*n + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_hi_q[n] <= '0;
        code_lo_q[n] <= '0;
      end else begin
        if (wr_ok && acc_addr_i == A_HI) code_hi_q[n] <= acc_data_i[HI_W-1:0];
        if (wr_ok && acc_addr_i == A_LO) code_lo_q[n] <= acc_data_i;
      end
    end
    assign code_o[n*CODE_W +: CODE_W] = {code_hi_q[n], code_lo_q[n]};
  end

  for (genvar k = 0; k < USER_N; k++) begin : g_user
    localparam logic [ADDR_W-1:0] A_U = ADDR_W'(A_USER0 + k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         user_q[k] <= '0;
      else if (wr_ok && acc_addr_i == A_U) user_q[k] <= acc_data_i;
    end
    assign user_o[k*DATA_W +: DATA_W] = user_q[k];
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_ID:    rd_data_o = ID_VAL;
      A_EN:    rd_data_o = {6'b0, en_q};
      A_LIM:   rd_data_o = {2'b0, lim_q};
      A_KEY:   rd_data_o = {7'b0, unlock_q};
      A_SYS:   rd_data_o = sys_q;
      default: rd_data_o = '0;
    endcase
    for (int n = 0; n < NUM_CODES; n++) begin
      if (rd_addr_i == ADDR_W'(A_CODE0 + 2*n))     rd_data_o = {{(DATA_W-HI_W){1'b0}}, code_hi_q[n]};
      if (rd_addr_i == ADDR_W'(A_CODE0 + 2*n + 1)) rd_data_o = code_lo_q[n];
    end
    for (int k = 0; k < USER_N; k++)
      if (rd_addr_i == ADDR_W'(A_USER0 + k)) rd_data_o = user_q[k];
  end

  assign en_o  = en_q;
  assign lim_o = lim_q;
  assign sys_o = sys_q;

  assert_locked_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_q |=> ($stable(sys_q) && $stable(user_o)));
  assert_unlock_seq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlock_q) |-> $past(armed_q));
  assert_relock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any && acc_addr_i == A_KEY && acc_data_i != KEY_A &&
     !(acc_data_i == KEY_B && armed_q)) |=> !unlock_q);
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_rb_pkg::*;
#(
  parameter int NUM_CODES   = 3,
  parameter int USER_N      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sclk_i,
  input  logic                        cs_ni,
  input  logic                        mosi_i,
  output logic                        miso_o,
  output logic                        miso_oe_o,
  output logic [1:0]                  en_o,
  output logic [5:0]                  lim_o,
  output logic [NUM_CODES*CODE_W-1:0] code_o,
  output logic [DATA_W-1:0]           sys_o,
  output logic [USER_N*DATA_W-1:0]    user_o
);
  logic              cs_s, sclk_s, mosi_s;
  logic [ADDR_W-1:0] rd_addr, acc_addr;
  logic [DATA_W-1:0] rd_data, acc_data;
  logic              acc_stb, acc_wr;

  spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, mosi_i}),
    .q_o    ({cs_s, sclk_s, mosi_s})
  );

  spi_rb_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_s_i     (cs_s),
    .sclk_s_i   (sclk_s),
    .mosi_s_i   (mosi_s),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .acc_stb_o  (acc_stb),
    .acc_wr_o   (acc_wr),
    .acc_addr_o (acc_addr),
    .acc_data_o (acc_data),
    .miso_o     (miso_o)
  );

  spi_rb_regs #(.NUM_CODES(NUM_CODES), .USER_N(USER_N)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_stb_i  (acc_stb),
    .acc_wr_i   (acc_wr),
    .acc_addr_i (acc_addr),
    .acc_data_i (acc_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .en_o       (en_o),
    .lim_o      (lim_o),
    .code_o     (code_o),
    .sys_o      (sys_o),
    .user_o     (user_o)
  );

  assign miso_oe_o = ~cs_s;
endmodule

// File: tb/spi_regbank_bench.sv
`timescale 1ns/1ps
module spi_regbank_bench;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  logic [1:0]  en;
  logic [5:0]  lim;
  logic [29:0] code;
  logic [7:0]  sys;
  logic [63:0] user;

  int checks = 0, failures = 0;
  int idle_cnt = 0;
  bit done = 0;

  // behavioural reference image
  logic [1:0] m_en;  logic [5:0] m_lim;
  logic [9:0] m_code [3];
  logic [7:0] m_sys; logic [7:0] m_user [8];
  bit m_unl, m_armed;
  logic [7:0] txb [16];
  logic [7:0] rxb [16];

  always #2.5 clk = ~clk;

  spi_regbank u_spi_regbank (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .en_o(en), .lim_o(lim), .code_o(code),
    .sys_o(sys), .user_o(user)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [6:0] a);
    if (a == 7'h00) return 8'hA6;
    if (a == 7'h01) return {6'b0, m_en};
    if (a == 7'h02) return {2'b0, m_lim};
    if (a >= 7'h03 && a <= 7'h08) begin
      int n = (a - 3) / 2;
      return ((a - 3) % 2 == 0) ? {6'b0, m_code[n][9:8]} : m_code[n][7:0];
    end
    if (a == 7'h10) return {7'b0, m_unl};
    if (a == 7'h11) return m_sys;
    if (a >= 7'h20 && a <= 7'h27) return m_user[a - 7'h20];
    return 8'h00;
  endfunction

  function automatic void m_access(input bit wr, input logic [6:0] a, input logic [7:0] d);
    bit prot = (a >= 7'h11 && a <= 7'h27);
    bit nxt = wr && a == 7'h10 && d == 8'hBA;
    if (wr && (!prot || m_unl)) begin
      if (a == 7'h01) m_en = d[1:0];
      if (a == 7'h02) m_lim = d[5:0];
      if (a >= 7'h03 && a <= 7'h08) begin
        int n = (a - 3) / 2;
        if ((a - 3) % 2 == 0) m_code[n][9:8] = d[1:0];
        else                  m_code[n][7:0] = d;
      end
      if (a == 7'h11) m_sys = d;
      if (a >= 7'h20 && a <= 7'h27) m_user[a - 7'h20] = d;
    end
    if (wr && a == 7'h10 && d != 8'hBA) m_unl = (d == 8'hBE) && m_armed;
    m_armed = nxt;
  endfunction

  task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  // one transfer: command byte and n data bytes from txb; read bytes checked
  task automatic xfer(input logic [7:0] cmd, input int n, input string req);
    logic [7:0] r;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(miso_oe === 1'b1, "R1 oe during select", miso_oe, 1);
    send_byte(cmd, r);
    for (int i = 0; i < n; i++) begin
      send_byte(txb[i], rxb[i]);
      if (!cmd[7]) begin
        logic [7:0] e = m_read(7'(cmd[6:0] + i));
        chk(rxb[i] === e, req, rxb[i], e);
      end
    end
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) m_access(cmd[7], 7'(cmd[6:0] + i), txb[i]);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d, input string req);
    txb[0] = d; xfer({1'b1, a}, 1, req);
  endtask

  task automatic rd(input logic [6:0] a, input int n, input string req);
    for (int i = 0; i < n; i++) txb[i] = 8'hFF;
    xfer({1'b0, a}, n, req);
  endtask

  // compare every clock while the port has been idle for a while
  always @(negedge clk) begin
    if (!rst_n || done) idle_cnt = 0;
    else begin
      idle_cnt = cs_n ? idle_cnt + 1 : 0;
      if (idle_cnt > 4) begin
        chk(miso_oe === 1'b0, "R1 oe idle", miso_oe, 0);
        chk(en === m_en, "R4 en_o", en, m_en);
        chk(lim === m_lim, "R5 lim_o", lim, m_lim);
        chk(code === {m_code[2], m_code[1], m_code[0]}, "R6 code_o", code,
            {m_code[2], m_code[1], m_code[0]});
        chk(sys === m_sys, "R7 sys_o", sys, m_sys);
        chk(user === {m_user[7], m_user[6], m_user[5], m_user[4], m_user[3], m_user[2],
                      m_user[1], m_user[0]}, "R7 user_o", user, 0);
      end
    end
  end

  initial begin
    #(150000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    m_en = 2'b11; m_lim = 6'h28; m_sys = 0; m_unl = 0; m_armed = 0;
    for (int i = 0; i < 3; i++) m_code[i] = 0;
    for (int i = 0; i < 8; i++) m_user[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R4 reset values, R2 read command, R3 increment
    rd(7'h00, 4, "R4 reset read");
    rd(7'h10, 2, "R4 key/sys reset");

    // R6 code split, R5 high bits masked, R2 write command, R3 burst
    txb[0] = 8'hFF; txb[1] = 8'h5A; txb[2] = 8'hFE; txb[3] = 8'h01;
    txb[4] = 8'h02; txb[5] = 8'hC3;
    xfer(8'h83, 6, "R6 write codes");
    rd(7'h03, 6, "R6 code readback");
    chk(code === {2'b10, 8'hC3, 2'b10, 8'h01, 2'b11, 8'h5A}, "R6 code_o value",
        code, {2'b10, 8'hC3, 2'b10, 8'h01, 2'b11, 8'h5A});

    // R5 read-only bits
    wr1(7'h00, 8'h55, "R5 id write");
    wr1(7'h01, 8'hFE, "R5 en write");
    wr1(7'h02, 8'hFF, "R5 lim write");
    rd(7'h00, 3, "R5 readback");
    chk(lim === 6'h3F, "R5 lim_o", lim, 6'h3F);

    // R7 locked window
    wr1(7'h11, 8'h77, "R7 locked write");
    txb[0] = 8'h11; txb[1] = 8'h22; xfer(8'hA0, 2, "R7 locked user");
    rd(7'h10, 2, "R7 locked read");
    rd(7'h20, 2, "R7 user locked read");

    // R8 broken sequence: read between keys
    wr1(7'h10, 8'hBA, "R8 key a");
    rd(7'h05, 1, "R8 interleaved read");
    wr1(7'h10, 8'hBE, "R8 key b late");
    rd(7'h10, 1, "R8 still locked");
    chk(m_unl == 0, "R8 model lock", m_unl, 0);

    // R8 proper unlock in separate transfers
    wr1(7'h10, 8'hBA, "R8 key a");
    wr1(7'h10, 8'hBE, "R8 key b");
    rd(7'h10, 1, "R9 unlocked reads 1");
    wr1(7'h11, 8'h3C, "R7 unlocked sys");
    for (int i = 0; i < 8; i++) txb[i] = 8'(8'h90 + i * 7);
    xfer(8'hA0, 8, "R7 unlocked user");
    rd(7'h20, 8, "R7 user readback");
    rd(7'h11, 1, "R7 sys readback");

    // R9 BA keeps unlock, other byte relocks
    wr1(7'h10, 8'hBA, "R9 BA keeps");
    rd(7'h10, 1, "R9 still unlocked");
    wr1(7'h10, 8'h00, "R9 relock");
    rd(7'h10, 1, "R9 locked reads 0");
    wr1(7'h11, 8'hEE, "R7 after relock");
    rd(7'h11, 1, "R7 relocked sys");

    // R3 wrap, R11 unmapped
    txb[0] = 8'h99; txb[1] = 8'h44; xfer(8'hFF, 2, "R11 wrap write");
    rd(7'h7F, 3, "R3 wrap read");
    wr1(7'h09, 8'hAB, "R11 unmapped write");
    rd(7'h09, 1, "R11 unmapped read");
    rd(7'h40, 2, "R11 unmapped range");

    // R10 read command data bytes commit nothing
    for (int i = 0; i < 4; i++) txb[i] = 8'h00;
    xfer(8'h01, 4, "R10 read with data");
    rd(7'h01, 2, "R10 unchanged");

    // R10 partial final byte
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    send_byte(8'h84, r);
    for (int i = 7; i >= 4; i--) begin
      mosi = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    rd(7'h04, 1, "R10 partial byte");

    // R1 activity with select high is ignored
    for (int i = 0; i < 24; i++) begin
      mosi = i[0];
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      chk(miso_oe === 1'b0, "R1 oe deselected", miso_oe, 0);
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
    repeat (10) @(negedge clk);
    rd(7'h00, 9, "R1 state after idle clocks");

    done = 1;
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule